// File: doc/BRIEF.md
# Retriggerable one-shot pulse generator

This block holds two independent one-shot timers. Each timer drives a high pulse of a programmed number of clock cycles when it sees a valid trigger. The trigger comes from a gated pair of inputs. A falling edge on the low-going input counts only while the high-going input is high. A rising edge on the high-going input counts only while the low-going input is low. A valid trigger that arrives during a pulse reloads the full length. Triggers repeated before expiry therefore keep the output high for as long as they continue.

Each channel has a low-active clear. While the clear is low, the pulse output is held low and every trigger edge is discarded. Taking the clear high again never starts a pulse by itself. All trigger and clear inputs are asynchronous to the clock and are resynchronised inside the block. The width value is a static setting per channel that the timer reads when it loads.

Top module: `retrig_oneshot`

## Requirements
- R1: A high-to-low change of `trig_n_i[c]` starts or restarts channel c only while `trig_p_i[c]` is 1. With `trig_p_i[c]` at 0 the change has no effect on `pulse_o[c]`.
- R2: A low-to-high change of `trig_p_i[c]` starts or restarts channel c only while `trig_n_i[c]` is 0. With `trig_n_i[c]` at 1 the change has no effect on `pulse_o[c]`.
- R3: Inputs are resynchronised through two flops and then compared with their previous sampled value. For a valid trigger applied before clock edge k, `pulse_o[c]` is 1 after edge k+2 and stays 1 for exactly W cycles, where W is `width_i[c*CNT_W +: CNT_W]`.
- R4: A valid trigger during a pulse reloads the full W cycles, so repeated triggers keep `pulse_o[c]` high with no low cycle.
- R5: `clear_n_i[c]` at 0, applied before edge k, makes `pulse_o[c]` 0 after edge k+2. While the clear stays 0, trigger edges do not raise the output. A clear and a trigger applied on the same edge give no pulse.
- R6: Changing `clear_n_i[c]` from 0 to 1 never starts a pulse, even when `trig_n_i[c]` is 0 and `trig_p_i[c]` is 1 at that moment.
- R7: `pulse_n_o[c]` is always the inverse of `pulse_o[c]`.
- R8: A width value of 0 gives a pulse of exactly 1 cycle.
- R9: The channels are independent: triggers, clears and widths of one channel never change the other channel's output.
- R10: While `rst_n` is 0, `pulse_o` is 0 and `pulse_n_o` is all ones. Trigger levels that are present or that change during reset do not produce a pulse after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_n_i | input | NUM_CH | Low-going trigger input, one bit per channel |
| trig_p_i | input | NUM_CH | High-going trigger input, one bit per channel |
| clear_n_i | input | NUM_CH | Active-low clear, one bit per channel |
| width_i | input | NUM_CH*CNT_W | Pulse width in cycles, one CNT_W field per channel |
| pulse_o | output | NUM_CH | Pulse output, high while the timer runs |
| pulse_n_o | output | NUM_CH | Inverse of pulse_o |

## Verification
Two functions can meet in the same cycle: a trigger being loaded and a clear taking effect. The two paths have the same synchronisation depth, so the bench provokes the collision by dropping the clear and the trigger input on the same clock edge. The bench judges the result by counting high cycles of the output, which must be zero. Trigger and clear also overlap inside the vector table, where a clear lands mid-pulse. There a cycle-accurate reference model checks every cycle, including the cycle in which the pulse ends and the following cycles in which further edges must be ignored.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
// Shared types for the retriggerable one-shot.
// Assumes: each channel's trigger and clear inputs are grouped into one record
// so that they can be resynchronised together.
package oneshot_pkg;

    // One channel's raw or synchronised input set.
    typedef struct packed {
        logic trig_n;   // low-going trigger
        logic trig_p;   // high-going trigger
        logic clear_n;  // active-low clear
    } chan_in_t;

    // Value held in the input pipeline while the chip reset is active:
    // triggers idle, clear asserted.
    localparam chan_in_t CHAN_IDLE = '{trig_n: 1'b1, trig_p: 1'b0, clear_n: 1'b0};

endpackage

// File: rtl/oneshot_sync.sv
`timescale 1ns/1ps
// Multi-stage resynchroniser for one channel's input record.
// Assumes: inputs may change at any time relative to clk; STAGES >= 1.
// The output is the input delayed by STAGES clock edges.
module oneshot_sync
    import oneshot_pkg::*;
#(
    parameter int       STAGES  = 2,
    parameter chan_in_t RST_VAL = CHAN_IDLE
) (
    input  logic     clk,
    input  logic     rst_n,
    input  chan_in_t d,
    output chan_in_t q
);

    chan_in_t stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= d;
            end
        end else begin : g_next
            // Later flops settle any metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/oneshot_edge.sv
`timescale 1ns/1ps
// Gated edge detector for one channel.
// It compares the synchronised inputs with their values from one cycle
// earlier. It flags a valid trigger when the low-going input falls while the
// high-going input is high, or when the high-going input rises while the
// low-going input is low.
// Assumes: `cur` is already synchronised. After reset the detector stays
// blind for WARMUP cycles, until the pipeline holds only real samples.
module oneshot_edge
    import oneshot_pkg::*;
#(
    parameter int WARMUP = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  chan_in_t cur,
    output logic     fire,
    output logic     hold_clear
);

    chan_in_t          prev;
    logic [WARMUP-1:0] fill;
    logic              live;
    logic              fall_n;
    logic              rise_p;

    // Keep last cycle's synchronised inputs for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= CHAN_IDLE;
        else        prev <= cur;
    end

    // Count the cycles since reset until the pipeline is full of live data.
    always_ff @(posedge clk) begin
        if (!rst_n) fill <= '0;
        else        fill <= {fill[WARMUP-2:0], 1'b1};
    end

    assign live = fill[WARMUP-1];

    // Raw edges with the gate condition of the opposite input.
    always_comb begin
        fall_n = prev.trig_n & ~cur.trig_n & cur.trig_p;
        rise_p = ~prev.trig_p & cur.trig_p & ~cur.trig_n;
    end

    assign hold_clear = ~live | ~cur.clear_n;
    assign fire       = ~hold_clear & (fall_n | rise_p);

    // A falling low-going input with the other input low never fires.
    p_gate_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (prev.trig_n && !cur.trig_n && !cur.trig_p) |-> !fire);

    // A rising high-going input while the other input is high never fires.
    p_gate_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev.trig_p && cur.trig_p && cur.trig_n) |-> !fire);

    // No trigger is accepted while the clear is low.
    p_clear_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cur.clear_n |-> !fire);

    // Steady trigger levels (for example at clear release) never fire.
    p_steady_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.trig_n == prev.trig_n && cur.trig_p == prev.trig_p) |-> !fire);

endmodule

// File: rtl/oneshot_timer.sv
`timescale 1ns/1ps
// Down-counter that times one pulse.
// A trigger loads the width (a width of 0 counts as 1). The output is high
// while the count is non-zero. The clear empties the counter at once and
// takes priority over a trigger in the same cycle.
// Assumes: `width` is stable while it is being loaded.
module oneshot_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             hold_clear,
    input  logic [CNT_W-1:0] width,
    output logic             active
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Raise a zero width to the one-cycle minimum.
    always_comb begin
        load_val = (width == '0) ? CNT_W'(1) : width;
    end

    // Clear first, then reload on a trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (hold_clear)     cnt_q <= '0;
        else if (fire)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign active = (cnt_q != '0);

    // A clear empties the counter on the next edge.
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clear |=> (cnt_q == '0));

    // A trigger reloads the full width, even in the middle of a pulse.
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hold_clear) |=> (cnt_q == $past(load_val)));

    // Without a trigger or clear, a running count drops by exactly one.
    p_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !hold_clear && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // A zero width still yields a running pulse.
    p_min_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hold_clear && width == '0) |=> active);

endmodule

// File: rtl/retrig_oneshot.sv
`timescale 1ns/1ps
// Multi-channel retriggerable one-shot.
// Each channel resynchronises its trigger pair and clear and detects gated
// edges. It then times the pulse with a reloadable down-counter and drives
// complementary outputs.
// Assumes: width_i is a static setting per channel; channels share only the
// clock and the chip reset.
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int CNT_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         trig_n_i,
    input  logic [NUM_CH-1:0]         trig_p_i,
    input  logic [NUM_CH-1:0]         clear_n_i,
    input  logic [NUM_CH*CNT_W-1:0]   width_i,
    output logic [NUM_CH-1:0]         pulse_o,
    output logic [NUM_CH-1:0]         pulse_n_o
);

    localparam int WARMUP = SYNC_DEPTH + 1;

    logic [NUM_CH-1:0] fire;
    logic [NUM_CH-1:0] hold_clear;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_in_t raw_in;
        chan_in_t syn_in;

        assign raw_in = '{trig_n: trig_n_i[c], trig_p: trig_p_i[c], clear_n: clear_n_i[c]};

        oneshot_sync #(
            .STAGES  (SYNC_DEPTH),
            .RST_VAL (CHAN_IDLE)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_in),
            .q     (syn_in)
        );

        oneshot_edge #(
            .WARMUP (WARMUP)
        ) u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .cur        (syn_in),
            .fire       (fire[c]),
            .hold_clear (hold_clear[c])
        );

        oneshot_timer #(
            .CNT_W (CNT_W)
        ) u_timer (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire       (fire[c]),
            .hold_clear (hold_clear[c]),
            .width      (width_i[c*CNT_W +: CNT_W]),
            .active     (pulse_o[c])
        );

        // Every rise of a pulse is caused by an accepted trigger one edge earlier.
        p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulse_o[c]) |-> $past(fire[c]));

        // The pulse is low on the edge after a clear is seen.
        p_clear_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            hold_clear[c] |=> !pulse_o[c]);
    end

    assign pulse_n_o = ~pulse_o;

endmodule

// File: tb/retrig_oneshot_tb_top.sv
`timescale 1ns/1ps
module retrig_oneshot_tb_top;

    localparam int NUM_CH = 2;
    localparam int CNT_W  = 16;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [NUM_CH-1:0]       trig_n;
    logic [NUM_CH-1:0]       trig_p;
    logic [NUM_CH-1:0]       clear_n;
    logic [NUM_CH*CNT_W-1:0] width;
    logic [NUM_CH-1:0]       pulse;
    logic [NUM_CH-1:0]       pulse_n;

    int    total = 0;
    int    bad   = 0;
    bit    chk_on = 1'b0;
    string cur_tag = "R10";

    always #4 clk = ~clk;

    retrig_oneshot #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_n_i  (trig_n),
        .trig_p_i  (trig_p),
        .clear_n_i (clear_n),
        .width_i   (width),
        .pulse_o   (pulse),
        .pulse_n_o (pulse_n)
    );

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic count_hi(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (pulse[ch]) hi++;
        end
    endtask

    function automatic logic [CNT_W-1:0] wsat(input logic [CNT_W-1:0] w);
        return (w == '0) ? CNT_W'(1) : w;
    endfunction

    // Reference model built from the requirements: two sync stages,
    // comparison with the previous sample, gating, priority of the clear,
    // and a warm-up after reset.
    logic [NUM_CH-1:0] h1a, h2a, h3a, h1b, h2b, h3b, h1c, h2c;
    int                mlive;
    logic [CNT_W-1:0]  mcnt [NUM_CH];

    always @(posedge clk) begin
        if (!rst_n) begin
            h1a = '1; h2a = '1; h3a = '1;
            h1b = '0; h2b = '0; h3b = '0;
            h1c = '0; h2c = '0;
            mlive = 0;
            for (int c = 0; c < NUM_CH; c++) mcnt[c] = '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                logic trg;
                logic clr;
                clr = (mlive < 3) || !h2c[c];
                trg = (h3a[c] && !h2a[c] && h2b[c]) || (!h3b[c] && h2b[c] && !h2a[c]);
                if (clr)            mcnt[c] = '0;
                else if (trg)       mcnt[c] = wsat(width[c*CNT_W +: CNT_W]);
                else if (mcnt[c] != '0) mcnt[c] = mcnt[c] - CNT_W'(1);
            end
            h3a = h2a; h3b = h2b;
            h2a = h1a; h2b = h1b; h2c = h1c;
            h1a = trig_n; h1b = trig_p; h1c = clear_n;
            if (mlive < 3) mlive++;
        end
    end

    // Checks on every cycle against the model, plus the complement (R7).
    always @(negedge clk) begin
        if (chk_on) begin
            for (int c = 0; c < NUM_CH; c++) begin
                chk(cur_tag, pulse[c], (mcnt[c] != '0), "model");
                chk("R7", pulse_n[c], ~pulse[c], "complement");
            end
        end
    end

    typedef struct packed {
        logic [3:0] tag;
        logic a0, b0, c0, a1, b1, c1;
        logic [7:0] hold;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd10, 1'b1,1'b0,1'b1, 1'b1,1'b0,1'b1, 8'd6},
        '{4'd1,  1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1, 8'd8},
        '{4'd1,  1'b1,1'b0,1'b1, 1'b1,1'b0,1'b1, 8'd4},
        '{4'd2,  1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1, 8'd8},
        '{4'd1,  1'b0,1'b1,1'b1, 1'b1,1'b0,1'b1, 8'd8},
        '{4'd2,  1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1, 8'd4},
        '{4'd2,  1'b0,1'b1,1'b1, 1'b1,1'b0,1'b1, 8'd8},
        '{4'd9,  1'b1,1'b0,1'b1, 1'b1,1'b1,1'b1, 8'd4},
        '{4'd9,  1'b1,1'b0,1'b1, 1'b0,1'b1,1'b1, 8'd12},
        '{4'd4,  1'b1,1'b1,1'b1, 1'b0,1'b1,1'b1, 8'd3},
        '{4'd4,  1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1, 8'd2},
        '{4'd4,  1'b1,1'b1,1'b1, 1'b0,1'b1,1'b1, 8'd1},
        '{4'd4,  1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1, 8'd2},
        '{4'd4,  1'b1,1'b1,1'b1, 1'b0,1'b1,1'b1, 8'd1},
        '{4'd4,  1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1, 8'd8},
        '{4'd5,  1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1, 8'd3},
        '{4'd5,  1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1, 8'd4},
        '{4'd5,  1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0, 8'd8},
        '{4'd6,  1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1, 8'd10}
    };

    function automatic string tag_s(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hi;
        rst_n   = 1'b0;
        trig_n  = '1;
        trig_p  = '0;
        clear_n = '1;
        width   = '0;
        width[0*CNT_W +: CNT_W] = CNT_W'(4);
        width[1*CNT_W +: CNT_W] = CNT_W'(7);
        @(negedge clk);
        tick(4);
        chk("R10", pulse[0], 1'b0, "reset pulse0");
        chk("R10", pulse[1], 1'b0, "reset pulse1");
        chk("R10", pulse_n[0], 1'b1, "reset pulse_n0");
        chk("R10", pulse_n[1], 1'b1, "reset pulse_n1");
        rst_n  = 1'b1;
        chk_on = 1'b1;

        // Table walk, judged every cycle by the model.
        for (int i = 0; i < NV; i++) begin
            cur_tag    = tag_s(VECS[i].tag);
            trig_n[0]  = VECS[i].a0;
            trig_p[0]  = VECS[i].b0;
            clear_n[0] = VECS[i].c0;
            trig_n[1]  = VECS[i].a1;
            trig_p[1]  = VECS[i].b1;
            clear_n[1] = VECS[i].c1;
            tick(int'(VECS[i].hold));
        end

        // R2: a rising high-going input with the low-going input high is ignored.
        cur_tag = "R3";
        width[0*CNT_W +: CNT_W] = CNT_W'(5);
        trig_n[0] = 1'b1; trig_p[0] = 1'b0;
        tick(4);
        trig_p[0] = 1'b1;
        tick(5);
        chk("R2", pulse[0], 1'b0, "ungated rise");

        // R3: rises on the third edge and lasts exactly W=5 cycles.
        trig_n[0] = 1'b0;
        tick(2);
        chk("R3", pulse[0], 1'b0, "before latency");
        tick(1);
        chk("R3", pulse[0], 1'b1, "first high cycle");
        count_hi(0, 10, hi);
        chk("R3", (hi == 4), 1'b1, "width 5");

        // R8: width 0 gives one cycle.
        cur_tag = "R8";
        width[0*CNT_W +: CNT_W] = '0;
        trig_n[0] = 1'b1;
        tick(4);
        trig_n[0] = 1'b0;
        count_hi(0, 10, hi);
        chk("R8", (hi == 1), 1'b1, "width 0");

        // R5: clear in mid-pulse drops the output on the third edge.
        cur_tag = "R5";
        width[0*CNT_W +: CNT_W] = CNT_W'(20);
        trig_n[0] = 1'b1;
        tick(4);
        trig_n[0] = 1'b0;
        tick(5);
        chk("R5", pulse[0], 1'b1, "pulse running");
        clear_n[0] = 1'b0;
        tick(2);
        chk("R5", pulse[0], 1'b1, "clear latency");
        tick(1);
        chk("R5", pulse[0], 1'b0, "clear lands");
        trig_n[0] = 1'b1;
        tick(3);
        trig_n[0] = 1'b0;
        tick(6);
        chk("R5", pulse[0], 1'b0, "edge under clear");

        // R6: clear release with trigger levels present starts nothing.
        cur_tag = "R6";
        clear_n[0] = 1'b1;
        count_hi(0, 10, hi);
        chk("R6", (hi == 0), 1'b1, "release quiet");

        // R5: clear and trigger on the same edge: clear wins.
        cur_tag = "R5";
        width[0*CNT_W +: CNT_W] = CNT_W'(6);
        trig_n[0] = 1'b1;
        tick(4);
        clear_n[0] = 1'b0;
        trig_n[0]  = 1'b0;
        count_hi(0, 10, hi);
        chk("R5", (hi == 0), 1'b1, "same-edge clear");
        clear_n[0] = 1'b1;
        count_hi(0, 6, hi);
        chk("R6", (hi == 0), 1'b1, "release after collision");

        // R10: trigger activity during chip reset leaves no pulse afterwards.
        cur_tag = "R10";
        rst_n = 1'b0;
        tick(3);
        trig_n[0] = 1'b1;
        tick(2);
        trig_n[0] = 1'b0;
        tick(3);
        chk("R10", pulse[0], 1'b0, "in reset ch0");
        chk("R10", pulse[1], 1'b0, "in reset ch1");
        rst_n = 1'b1;
        count_hi(0, 10, hi);
        chk("R10", (hi == 0), 1'b1, "after reset ch0");
        chk("R9", pulse[1], 1'b0, "ch1 untouched");

        chk_on = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule